// File: doc/BRIEF.md
# Registered Custom-Function Arithmetic Logic Unit

This block is the integer datapath unit of a small load/store core. Every cycle it takes two operands, a six-bit function code and a shift count. It computes one of sixteen functions: add, subtract, the bitwise family, multiply, unsigned divide and remainder, three shifts and single-bit rotates. The result is captured in an output register, together with a flag that is set when that result is zero. Operand muxing and immediate extension are done upstream, so the block sees only ready-made operands.

All sixteen function codes share the prefix `11` in bits 5:4, and the low four bits pick the function. The arithmetic, bitwise and shift groups are each built as a separate unit. The top module merges their results and registers the merged value, so the result appears one clock after the inputs are presented.

Top module: `cfalu_core`

## Requirements
- R1: While `rst_n` is low, `result_o` is 0 and `zero_o` is 1.
- R2: The result for the inputs sampled at a rising edge appears on `result_o` after that edge. Add (110000) and subtract (110001) wrap modulo 2^32.
- R3: and (110010), or (110011), nand (111101), nor (111110) and xor (111111) are applied bit by bit; nand and nor are the complements of and and of or.
- R4: not (110100) returns the bitwise complement of `opa_i`, and `opb_i` has no effect on the result.
- R5: mul (110101) returns the low 32 bits of the product.
- R6: div (110110) and mod (110111) treat both operands as unsigned.
- R7: With `opb_i` equal to 0, div returns all ones and mod returns `opa_i`.
- R8: sra (111000) shifts `opa_i` right by `shamt_i` and fills the vacated bits with bit 31.
- R9: sll (111001) and srl (111010) shift `opa_i` by `shamt_i` (0 to 31) and fill with zeros; a count of 0 returns `opa_i`.
- R10: rol (111011) and ror (111100) rotate `opa_i` by exactly one bit, left or right.
- R11: `zero_o` is 1 exactly when `result_o` is 0.
- R12: A function code whose bits 5:4 are not `11` yields a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand (divisor for div and mod) |
| func_i | input | 6 | Function code |
| shamt_i | input | 5 | Shift count for sra, sll and srl |
| result_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered flag, set when the result is zero |

## Verification
The bench builds the block with its default 32-bit data width, which gives a 5-bit shift count. At that width the shift counts 0 and 31 can both be applied, so both ends of every shift are reached. The product of 2^16 by 2^16 wraps to zero in the low word, and the sign fill of sra starts from bit 31. The same width fixes the all-ones value returned by a zero-divisor divide, so that corner can be stated and checked as a literal.

// File: rtl/cfalu_pkg.sv
package cfalu_pkg;
  localparam int unsigned FUNC_W = 6;

  typedef enum logic [FUNC_W-1:0] {
    FN_ADD  = 6'b110000,
    FN_SUB  = 6'b110001,
    FN_AND  = 6'b110010,
    FN_OR   = 6'b110011,
    FN_NOT  = 6'b110100,
    FN_MUL  = 6'b110101,
    FN_DIV  = 6'b110110,
    FN_MOD  = 6'b110111,
    FN_SRA  = 6'b111000,
    FN_SLL  = 6'b111001,
    FN_SRL  = 6'b111010,
    FN_ROL  = 6'b111011,
    FN_ROR  = 6'b111100,
    FN_NAND = 6'b111101,
    FN_NOR  = 6'b111110,
    FN_XOR  = 6'b111111
  } fn_e;
endpackage

// File: rtl/cfalu_arith.sv
module cfalu_arith
  import cfalu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [FUNC_W-1:0] fn_i,
  output logic [DATA_W-1:0] res_o,
  output logic              hit_o
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic div_by_zero;
  assign div_by_zero = (b_i == '0);

  always_comb begin
    res_o = '0;
    hit_o = 1'b1;
    case (fn_i)
      FN_ADD:  res_o = a_i + b_i;
      FN_SUB:  res_o = a_i - b_i;
      FN_MUL:  res_o = a_i * b_i;
      FN_DIV:  res_o = div_by_zero ? ALL_ONES : (a_i / b_i);
      FN_MOD:  res_o = div_by_zero ? a_i : (a_i % b_i);
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfalu_bitwise.sv
module cfalu_bitwise
  import cfalu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [FUNC_W-1:0] fn_i,
  output logic [DATA_W-1:0] res_o,
  output logic              hit_o
);
  logic [DATA_W-1:0] v_and, v_or, v_xor;

  // One slice per bit; the complemented forms are taken from these.
  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    assign v_and[k] = a_i[k] & b_i[k];
    assign v_or[k]  = a_i[k] | b_i[k];
    assign v_xor[k] = a_i[k] ^ b_i[k];
  end

  always_comb begin
    res_o = '0;
    hit_o = 1'b1;
    case (fn_i)
      FN_AND:  res_o = v_and;
      FN_OR:   res_o = v_or;
      FN_XOR:  res_o = v_xor;
      FN_NAND: res_o = ~v_and;
      FN_NOR:  res_o = ~v_or;
      FN_NOT:  res_o = ~a_i;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfalu_shift.sv
module cfalu_shift
  import cfalu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [SHAMT_W-1:0] sh_i,
  input  logic [FUNC_W-1:0]  fn_i,
  output logic [DATA_W-1:0]  res_o,
  output logic               hit_o
);
  logic [DATA_W-1:0] v_sra;
  assign v_sra = DATA_W'($signed(a_i) >>> sh_i);

  always_comb begin
    res_o = '0;
    hit_o = 1'b1;
    case (fn_i)
      FN_SRA:  res_o = v_sra;
      FN_SLL:  res_o = a_i << sh_i;
      FN_SRL:  res_o = a_i >> sh_i;
      FN_ROL:  res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
      FN_ROR:  res_o = {a_i[0], a_i[DATA_W-1:1]};
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfalu_core.sv
module cfalu_core
  import cfalu_pkg::*;
#(
  parameter  int unsigned DATA_W  = 32,
  localparam int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  opa_i,
  input  logic [DATA_W-1:0]  opb_i,
  input  logic [FUNC_W-1:0]  func_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               zero_o
);
  logic [DATA_W-1:0] ar_res, lg_res, sh_res;
  logic              ar_hit, lg_hit, sh_hit;
  logic [DATA_W-1:0] res_d;
  logic              zero_d;

  cfalu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i(opa_i), .b_i(opb_i), .fn_i(func_i), .res_o(ar_res), .hit_o(ar_hit)
  );

  cfalu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
    .a_i(opa_i), .b_i(opb_i), .fn_i(func_i), .res_o(lg_res), .hit_o(lg_hit)
  );

  cfalu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .a_i(opa_i), .sh_i(shamt_i), .fn_i(func_i), .res_o(sh_res), .hit_o(sh_hit)
  );

  // Next-state: units return zero when not selected, so a plain OR merges them.
  always_comb begin
    res_d  = ar_res | lg_res | sh_res;
    zero_d = (res_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      zero_o   <= 1'b1;
    end else begin
      result_o <= res_d;
      zero_o   <= zero_d;
    end
  end
endmodule

// File: rtl/cfalu_core_chk.sv
module cfalu_core_chk
  import cfalu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [DATA_W-1:0]  opa_i,
  input logic [DATA_W-1:0]  opb_i,
  input logic [FUNC_W-1:0]  func_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic [DATA_W-1:0]  result_o,
  input logic               zero_o,
  input logic               ar_hit,
  input logic               lg_hit,
  input logic               sh_hit
);
  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assert_add_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(func_i) == FN_ADD) |-> (result_o == DATA_W'($past(opa_i) + $past(opb_i))));

  assert_not_ignores_b_R4: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(func_i) == FN_NOT) |-> (result_o == ~$past(opa_i)));

  assert_div_zero_R7: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(func_i) == FN_DIV && $past(opb_i) == '0) |-> (result_o == '1));

  assert_mod_zero_R7: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(func_i) == FN_MOD && $past(opb_i) == '0) |-> (result_o == $past(opa_i)));

  assert_rol_one_R10: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(func_i) == FN_ROL) |->
      (result_o == {$past(opa_i[DATA_W-2:0]), $past(opa_i[DATA_W-1])}));

  assert_zero_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o == (result_o == '0));

  assert_undefined_code_R12: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(func_i[5:4]) != 2'b11) |-> (result_o == '0));

  assert_single_unit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ar_hit, lg_hit, sh_hit}));
endmodule

bind cfalu_core cfalu_core_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .opa_i(opa_i), .opb_i(opb_i), .func_i(func_i),
  .shamt_i(shamt_i), .result_o(result_o), .zero_o(zero_o),
  .ar_hit(ar_hit), .lg_hit(lg_hit), .sh_hit(sh_hit)
);

// File: tb/test_cfalu_core.sv
module test_cfalu_core;
  localparam int unsigned DW = 32;

  logic          clk;
  logic          rst_n;
  logic [DW-1:0] opa, opb;
  logic [5:0]    fn;
  logic [4:0]    sh;
  logic [DW-1:0] res;
  logic          zf;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  cfalu_core i_cfalu_core (
    .clk(clk), .rst_n(rst_n), .opa_i(opa), .opb_i(opb), .func_i(fn),
    .shamt_i(sh), .result_o(res), .zero_o(zf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [5:0]    f;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    logic [4:0]    s;
    logic [DW-1:0] e;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{6'b110000, 32'd5,        32'd7,        5'd0,  32'h0000000C}, // R2 add
    '{6'b110001, 32'd3,        32'd5,        5'd0,  32'hFFFFFFFE}, // R2 sub wrap
    '{6'b110010, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  32'hF000F000}, // R3 and
    '{6'b110011, 32'hF0F0F0F0, 32'h0F0F0000, 5'd0,  32'hFFFFF0F0}, // R3 or
    '{6'b110100, 32'h00000000, 32'h12345678, 5'd0,  32'hFFFFFFFF}, // R4 not
    '{6'b110101, 32'h00010000, 32'h00010000, 5'd0,  32'h00000000}, // R5 mul wraps
    '{6'b110101, 32'hFFFFFFFD, 32'd5,        5'd0,  32'hFFFFFFF1}, // R5 mul low word
    '{6'b110110, 32'd100,      32'd7,        5'd0,  32'd14},       // R6 div
    '{6'b110111, 32'd100,      32'd7,        5'd0,  32'd2},        // R6 mod
    '{6'b110110, 32'h80000000, 32'd2,        5'd0,  32'h40000000}, // R6 unsigned div
    '{6'b111000, 32'h80000000, 32'd0,        5'd4,  32'hF8000000}, // R8 sra
    '{6'b111000, 32'h40000000, 32'd0,        5'd30, 32'h00000001}, // R8 sra positive
    '{6'b111001, 32'h00000001, 32'd0,        5'd31, 32'h80000000}, // R9 sll
    '{6'b111010, 32'h80000000, 32'd0,        5'd31, 32'h00000001}, // R9 srl
    '{6'b111011, 32'h80000001, 32'd0,        5'd7,  32'h00000003}, // R10 rol
    '{6'b111100, 32'h80000001, 32'd0,        5'd7,  32'hC0000000}, // R10 ror
    '{6'b111101, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0,  32'h00000000}, // R3 nand
    '{6'b111111, 32'hA5A5A5A5, 32'hFFFF0000, 5'd0,  32'h5A5AA5A5}  // R3 xor
  };

  function automatic string tag_of(input logic [5:0] f);
    case (f)
      6'b110000, 6'b110001:                         return "R2";
      6'b110010, 6'b110011, 6'b111101,
      6'b111110, 6'b111111:                         return "R3";
      6'b110100:                                    return "R4";
      6'b110101:                                    return "R5";
      6'b110110, 6'b110111:                         return "R6";
      6'b111000:                                    return "R8";
      6'b111001, 6'b111010:                         return "R9";
      6'b111011, 6'b111100:                         return "R10";
      default:                                      return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; the register loads at the next rising edge;
  // sample at the falling edge after it.
  task automatic apply(input logic [5:0] f, input logic [DW-1:0] a,
                       input logic [DW-1:0] b, input logic [4:0] s);
    @(negedge clk);
    fn = f; opa = a; opb = b; sh = s;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    fn = 6'b110000; opa = 32'd9; opb = 32'd9; sh = '0;
    repeat (3) @(negedge clk);
    check("R1", res, 32'd0);
    check("R1", {31'd0, zf}, 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].f, VECS[i].a, VECS[i].b, VECS[i].s);
      check(tag_of(VECS[i].f), res, VECS[i].e);
      check("R11", {31'd0, zf}, {31'd0, VECS[i].e == 32'd0});
    end

    // R3: nor of zeros
    apply(6'b111110, 32'd0, 32'd0, 5'd0);
    check("R3", res, 32'hFFFFFFFF);

    // R4: same A, different B gives the same result
    apply(6'b110100, 32'h0F0F0F0F, 32'hFFFFFFFF, 5'd0);
    check("R4", res, 32'hF0F0F0F0);
    apply(6'b110100, 32'h0F0F0F0F, 32'h00000000, 5'd0);
    check("R4", res, 32'hF0F0F0F0);

    // R7: zero divisor
    apply(6'b110110, 32'h12345678, 32'd0, 5'd0);
    check("R7", res, 32'hFFFFFFFF);
    apply(6'b110111, 32'h12345678, 32'd0, 5'd0);
    check("R7", res, 32'h12345678);

    // R9: shift count 0 leaves A unchanged
    apply(6'b111001, 32'hDEADBEEF, 32'd0, 5'd0);
    check("R9", res, 32'hDEADBEEF);
    apply(6'b111010, 32'hDEADBEEF, 32'd0, 5'd0);
    check("R9", res, 32'hDEADBEEF);

    // R12: codes outside the 11xxxx range
    apply(6'b000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3);
    check("R12", res, 32'd0);
    check("R11", {31'd0, zf}, 32'd1);
    apply(6'b100000, 32'd1, 32'd2, 5'd0);
    check("R12", res, 32'd0);

    // R2: result follows inputs with one register of delay
    @(negedge clk);
    fn = 6'b110000; opa = 32'd40; opb = 32'd2;
    check("R2", res, 32'd0);
    @(negedge clk);
    check("R2", res, 32'd42);

    // R1: asynchronous reset clears a non-zero result
    rst_n = 1'b0;
    #1;
    check("R1", res, 32'd0);
    check("R1", {31'd0, zf}, 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule